// File: doc/BRIEF.md
# Register Rename Unit with Free List and Checkpoints

This block renames one instruction per cycle for a machine whose only register storage is a single unified physical register file. No separate architectural register state exists: each architectural index is just an entry in a mapping table that points into the physical file. The physical register number it hands out is also the tag that consumers use for wakeup. For each request the unit looks up the current physical names of both sources. It takes the next free physical register for the destination and writes that into the table. It also reports the destination's previous physical name, so the commit logic can return that name to the free list once the instruction retires.

Speculation is handled with a small set of snapshot slots. A request flagged as a branch stores a copy of the mapping table and of the free-list read position into a slot chosen by the caller. Any later recovery through that slot puts both back in one cycle. Architectural register 0 is wired to physical register 0, which is always ready and never allocated. When no free register is left, the unit raises a stall and accepts nothing until a commit returns a register.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds registers NUM_ARCH to NUM_PHYS-1 in ascending order, with NUM_ARCH handed out first. `ren_stall` is low.
- R2: `ren_psrc1` and `ren_psrc2` show, in the same cycle, the mapping of `ren_src1` and `ren_src2` as left by all earlier accepted requests. They do not reflect the destination write of the current request.
- R3: An accepted request with a non-zero destination receives the register at the head of the free list on `ren_pdst` in the same cycle. Later requests see the destination mapped to that register. Registers leave the free list in first-in first-out order.
- R4: `ren_pold` shows the physical register the destination was mapped to before the current request.
- R5: Architectural register 0 always reads as physical 0. A request whose destination is 0 shows 0 on `ren_pdst` and `ren_pold`, consumes no free register and changes no mapping.
- R6: `ren_stall` is high exactly when the free list is empty. A request made while it is high changes neither the mapping table nor the free list.
- R7: `free_valid` appends `free_preg` to the tail of the free list. A stall caused by an empty list clears in the cycle after the release.
- R8: An accepted request with `ren_ckpt` high saves, into slot `ren_ckpt_slot`, the mapping table including that request's own update, and the free-list head position after its own allocation.
- R9: `rec_valid` restores the mapping table and the free-list head from slot `rec_slot` at the next clock edge. A rename request presented in the same cycle is discarded. A release in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_src1 | input | $clog2(NUM_ARCH) | First source architectural index |
| ren_src2 | input | $clog2(NUM_ARCH) | Second source architectural index |
| ren_dst | input | $clog2(NUM_ARCH) | Destination architectural index |
| ren_ckpt | input | 1 | Save a snapshot after this request |
| ren_ckpt_slot | input | $clog2(NUM_CKPT) | Snapshot slot to write |
| ren_stall | output | 1 | Free list empty, request not accepted |
| ren_psrc1 | output | $clog2(NUM_PHYS) | Physical tag of first source |
| ren_psrc2 | output | $clog2(NUM_PHYS) | Physical tag of second source |
| ren_pdst | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| ren_pold | output | $clog2(NUM_PHYS) | Previous physical mapping of destination |
| free_valid | input | 1 | Return a register at commit |
| free_preg | input | $clog2(NUM_PHYS) | Register being returned |
| rec_valid | input | 1 | Mis-speculation recovery |
| rec_slot | input | $clog2(NUM_CKPT) | Snapshot slot to restore |

## Verification
A corrupted mapping entry shows up on `ren_psrc1`/`ren_psrc2` as soon as a later request names that architectural register. It also shows up as a wrong `ren_pold` on the next rename of that register, so one read cycle exposes it. A free-list pointer that is off by one produces a wrong `ren_pdst` on the very next allocation, or a stall that rises or falls one cycle off the count of registers handed out. A snapshot that was saved or restored wrongly becomes visible in the first cycle after recovery: the source reads of rolled-back registers are wrong, or the first allocation after recovery does not reuse the register that was handed out right after the branch.

// File: rtl/rn_pkg.sv
// Package: default sizing shared by the rename unit and its checker.
// Assumes power-of-two physical and snapshot counts.
package rn_pkg;
    parameter int RN_NUM_ARCH = 16;
    parameter int RN_NUM_PHYS = 32;
    parameter int RN_NUM_CKPT = 4;
endpackage

// File: rtl/rn_map_table.sv
// Mapping table: architectural index -> physical register, with snapshot
// slots. Three combinational read ports, one write port. Snapshots hold the
// next-state table so a saving request's own write is included. Assumes the
// caller never writes entry 0 and never saves and restores in one cycle.
module rn_map_table #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS,
    parameter int NUM_CKPT = rn_pkg::RN_NUM_CKPT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_ARCH)-1:0] rd1_idx,
    input  logic [$clog2(NUM_ARCH)-1:0] rd2_idx,
    input  logic [$clog2(NUM_ARCH)-1:0] rdd_idx,
    output logic [$clog2(NUM_PHYS)-1:0] rd1_p,
    output logic [$clog2(NUM_PHYS)-1:0] rd2_p,
    output logic [$clog2(NUM_PHYS)-1:0] rdd_p,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_ARCH)-1:0] wr_idx,
    input  logic [$clog2(NUM_PHYS)-1:0] wr_p,
    input  logic                        save,
    input  logic [$clog2(NUM_CKPT)-1:0] save_slot,
    input  logic                        restore,
    input  logic [$clog2(NUM_CKPT)-1:0] restore_slot
);
    localparam int PW = $clog2(NUM_PHYS);

    logic [PW-1:0] map_q    [NUM_ARCH];
    logic [PW-1:0] map_next [NUM_ARCH];
    logic [PW-1:0] snap_q   [NUM_CKPT][NUM_ARCH];

    // Read ports see only the registered table.
    assign rd1_p = map_q[rd1_idx];
    assign rd2_p = map_q[rd2_idx];
    assign rdd_p = map_q[rdd_idx];

    // Next-state table: current table plus this cycle's destination write.
    always_comb begin
        map_next = map_q;
        if (wr_en) begin
            map_next[wr_idx] = wr_p;
        end
    end

    // Live table: identity on reset, snapshot on restore, else next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (restore) begin
            map_q <= snap_q[restore_slot];
        end else begin
            map_q <= map_next;
        end
    end

    // One snapshot register bank per slot.
    for (genvar s = 0; s < NUM_CKPT; s++) begin : g_snap
        // Capture the next-state table when this slot is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NUM_ARCH; i++) begin
                    snap_q[s][i] <= PW'(i);
                end
            end else if (save && (save_slot == s)) begin
                snap_q[s] <= map_next;
            end
        end
    end
endmodule

// File: rtl/rn_free_list.sv
// Free list of physical registers as a circular queue with wrap-bit
// pointers. The head is read combinationally. Snapshots keep only the head
// pointer, because the entries between a saved head and the live head are
// never overwritten while those registers are in flight. Assumes releases
// never exceed capacity and never return register 0.
module rn_free_list #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS,
    parameter int NUM_CKPT = rn_pkg::RN_NUM_CKPT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc,
    output logic [$clog2(NUM_PHYS)-1:0] head_preg,
    output logic                        empty,
    output logic [$clog2(NUM_PHYS):0]   count,
    output logic [$clog2(NUM_PHYS):0]   head_ptr,
    input  logic                        rel,
    input  logic [$clog2(NUM_PHYS)-1:0] rel_preg,
    input  logic                        save,
    input  logic [$clog2(NUM_CKPT)-1:0] save_slot,
    input  logic                        restore,
    input  logic [$clog2(NUM_CKPT)-1:0] restore_slot
);
    localparam int PW       = $clog2(NUM_PHYS);
    localparam int QW       = PW + 1;
    localparam int INIT_CNT = NUM_PHYS - NUM_ARCH;

    logic [PW-1:0] slots_q [NUM_PHYS];
    logic [QW-1:0] head_q, tail_q, head_next;
    logic [QW-1:0] snap_head_q [NUM_CKPT];

    assign head_preg = slots_q[head_q[PW-1:0]];
    assign count     = tail_q - head_q;
    assign empty     = (count == '0);
    assign head_ptr  = head_q;
    assign head_next = alloc ? head_q + QW'(1) : head_q;

    // Pointer update: restore overrides allocation, release always moves tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= QW'(INIT_CNT);
        end else begin
            head_q <= restore ? snap_head_q[restore_slot] : head_next;
            if (rel) begin
                tail_q <= tail_q + QW'(1);
            end
        end
    end

    // Queue storage: preloaded with the non-identity registers, written at tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_PHYS; k++) begin
                slots_q[k] <= (k < INIT_CNT) ? PW'(NUM_ARCH + k) : '0;
            end
        end else if (rel) begin
            slots_q[tail_q[PW-1:0]] <= rel_preg;
        end
    end

    // Per-slot saved head pointer.
    for (genvar s = 0; s < NUM_CKPT; s++) begin : g_snap
        // Keep the post-allocation head of a saving request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_head_q[s] <= '0;
            end else if (save && (save_slot == s)) begin
                snap_head_q[s] <= head_next;
            end
        end
    end
endmodule

// File: rtl/rn_rename_unit.sv
// Rename unit top: one rename per cycle, source lookup, destination
// allocation, previous-mapping report, branch snapshots and recovery.
// Architectural register 0 is pinned to physical 0. Assumes
// NUM_PHYS > NUM_ARCH, both powers of two, NUM_CKPT >= 2 and a power of two.
module rn_rename_unit #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS,
    parameter int NUM_CKPT = rn_pkg::RN_NUM_CKPT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ren_valid,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_src1,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_src2,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_dst,
    input  logic                        ren_ckpt,
    input  logic [$clog2(NUM_CKPT)-1:0] ren_ckpt_slot,
    output logic                        ren_stall,
    output logic [$clog2(NUM_PHYS)-1:0] ren_psrc1,
    output logic [$clog2(NUM_PHYS)-1:0] ren_psrc2,
    output logic [$clog2(NUM_PHYS)-1:0] ren_pdst,
    output logic [$clog2(NUM_PHYS)-1:0] ren_pold,
    input  logic                        free_valid,
    input  logic [$clog2(NUM_PHYS)-1:0] free_preg,
    input  logic                        rec_valid,
    input  logic [$clog2(NUM_CKPT)-1:0] rec_slot
);
    localparam int PW = $clog2(NUM_PHYS);

    logic          accept;
    logic          dst_live;
    logic          take_reg;
    logic          snap_save;
    logic [PW-1:0] head_preg;
    logic [PW-1:0] cur_dst_p;
    logic          fl_empty;
    logic [PW:0]   fl_count;
    logic [PW:0]   fl_head_ptr;

    // Acceptance: a request proceeds only with a free register and no recovery.
    assign accept    = ren_valid && !fl_empty && !rec_valid;
    assign dst_live  = (ren_dst != '0);
    assign take_reg  = accept && dst_live;
    assign snap_save = accept && ren_ckpt;

    assign ren_stall = fl_empty;
    assign ren_pdst  = dst_live ? head_preg : '0;
    assign ren_pold  = dst_live ? cur_dst_p : '0;

    rn_map_table #(
        .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd1_idx     (ren_src1),
        .rd2_idx     (ren_src2),
        .rdd_idx     (ren_dst),
        .rd1_p       (ren_psrc1),
        .rd2_p       (ren_psrc2),
        .rdd_p       (cur_dst_p),
        .wr_en       (take_reg),
        .wr_idx      (ren_dst),
        .wr_p        (head_preg),
        .save        (snap_save),
        .save_slot   (ren_ckpt_slot),
        .restore     (rec_valid),
        .restore_slot(rec_slot)
    );

    rn_free_list #(
        .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)
    ) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (take_reg),
        .head_preg   (head_preg),
        .empty       (fl_empty),
        .count       (fl_count),
        .head_ptr    (fl_head_ptr),
        .rel         (free_valid),
        .rel_preg    (free_preg),
        .save        (snap_save),
        .save_slot   (ren_ckpt_slot),
        .restore     (rec_valid),
        .restore_slot(rec_slot)
    );
endmodule

// File: rtl/rn_rename_chk.sv
// Checker for the rename unit, bound to every instance of the top.
module rn_rename_chk #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ren_valid,
    input logic [$clog2(NUM_ARCH)-1:0] ren_src1,
    input logic [$clog2(NUM_ARCH)-1:0] ren_dst,
    input logic                        ren_stall,
    input logic [$clog2(NUM_PHYS)-1:0] ren_psrc1,
    input logic [$clog2(NUM_PHYS)-1:0] ren_pdst,
    input logic [$clog2(NUM_PHYS)-1:0] ren_pold,
    input logic                        rec_valid,
    input logic                        free_valid,
    input logic [$clog2(NUM_PHYS)-1:0] free_preg,
    input logic [$clog2(NUM_PHYS):0]   fl_count,
    input logic [$clog2(NUM_PHYS):0]   fl_head_ptr
);
    AST_ZERO_DST_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_dst == '0) |-> (ren_pdst == '0 && ren_pold == '0)); // R5
    AST_ZERO_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src1 == '0) |-> (ren_psrc1 == '0)); // R5
    AST_ALLOC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_stall && ren_dst != '0) |-> (ren_pdst != '0)); // R3
    AST_STALL_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_stall && !rec_valid) |=> (fl_head_ptr == $past(fl_head_ptr))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (fl_count < ($clog2(NUM_PHYS)+1)'(NUM_PHYS))); // R7
    AST_FREE_NOT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (free_preg != '0)); // R5
endmodule

bind rn_rename_unit rn_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ren_valid  (ren_valid),
    .ren_src1   (ren_src1),
    .ren_dst    (ren_dst),
    .ren_stall  (ren_stall),
    .ren_psrc1  (ren_psrc1),
    .ren_pdst   (ren_pdst),
    .ren_pold   (ren_pold),
    .rec_valid  (rec_valid),
    .free_valid (free_valid),
    .free_preg  (free_preg),
    .fl_count   (fl_count),
    .fl_head_ptr(fl_head_ptr)
);

// File: tb/rn_rename_unit_bench.sv
`timescale 1ns/1ps
module rn_rename_unit_bench;
    localparam int NA = 16;
    localparam int NP = 32;
    localparam int NC = 4;
    localparam int AW = $clog2(NA);
    localparam int PW = $clog2(NP);
    localparam int CW = $clog2(NC);

    // Vector fields: dst, src1, src2, exp_psrc1, exp_psrc2, exp_pdst, exp_pold
    localparam int NVEC = 6;
    localparam int VEC [NVEC][7] = '{
        '{1, 2, 3,  2,  3, 16,  1},
        '{2, 1, 1, 16, 16, 17,  2},
        '{1, 1, 2, 16, 17, 18, 16},
        '{0, 1, 0, 18,  0,  0,  0},
        '{5, 0, 2,  0, 17, 19,  5},
        '{1, 5, 1, 19, 18, 20, 18}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [AW-1:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
    logic          ren_ckpt = 1'b0;
    logic [CW-1:0] ren_ckpt_slot = '0;
    logic          ren_stall;
    logic [PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
    logic          free_valid = 1'b0;
    logic [PW-1:0] free_preg = '0;
    logic          rec_valid = 1'b0;
    logic [CW-1:0] rec_slot = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rn_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) u_rn_rename_unit (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src1(ren_src1),
        .ren_src2(ren_src2), .ren_dst(ren_dst), .ren_ckpt(ren_ckpt),
        .ren_ckpt_slot(ren_ckpt_slot), .ren_stall(ren_stall), .ren_psrc1(ren_psrc1),
        .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
        .free_valid(free_valid), .free_preg(free_preg), .rec_valid(rec_valid),
        .rec_slot(rec_slot)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a request after the falling edge, let outputs settle.
    task automatic drive(input logic v, input int d, input int s1, input int s2,
                         input logic ck, input int slot);
        @(negedge clk);
        ren_valid = v; ren_dst = AW'(d); ren_src1 = AW'(s1); ren_src2 = AW'(s2);
        ren_ckpt = ck; ren_ckpt_slot = CW'(slot);
        free_valid = 1'b0; rec_valid = 1'b0;
        #1;
    endtask

    task automatic idle_read(input int s1, input int s2);
        drive(1'b0, 0, s1, s2, 1'b0, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset identity mapping and no stall
        idle_read(7, 15);
        chk("R1 psrc1", ren_psrc1, 7);
        chk("R1 psrc2", ren_psrc2, 15);
        chk("R1 stall", ren_stall, 0);

        // Vector walk: R2 sources, R3 allocation, R4 old mapping, R5 zero
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, 0);
            chk("R2 psrc1", ren_psrc1, VEC[i][3]);
            chk("R2 psrc2", ren_psrc2, VEC[i][4]);
            chk("R3 pdst", ren_pdst, VEC[i][5]);
            chk("R4 pold", ren_pold, VEC[i][6]);
        end

        // R8: rename r3 with snapshot into slot 1
        drive(1'b1, 3, 3, 0, 1'b1, 1);
        chk("R8 pdst", ren_pdst, 21);
        chk("R8 pold", ren_pold, 3);
        drive(1'b1, 3, 3, 0, 1'b0, 0);
        chk("R3 pdst after snap", ren_pdst, 22);
        drive(1'b1, 1, 1, 0, 1'b0, 0);
        chk("R4 pold r1", ren_pold, 20);
        chk("R3 pdst r1", ren_pdst, 23);

        // R9: restore slot 1 with a competing rename that must be dropped
        drive(1'b1, 3, 0, 0, 1'b0, 0);
        rec_valid = 1'b1; rec_slot = CW'(1);
        @(negedge clk);
        rec_valid = 1'b0; ren_valid = 1'b0;
        ren_src1 = AW'(3); ren_src2 = AW'(1);
        #1;
        chk("R9 r3 restored", ren_psrc1, 21);
        chk("R9 r1 restored", ren_psrc2, 20);
        drive(1'b1, 7, 0, 0, 1'b0, 0);
        chk("R9 head rolled back", ren_pdst, 22);
        chk("R4 pold r7", ren_pold, 7);

        // R6: drain the remaining nine registers
        for (int k = 0; k < 9; k++) begin
            drive(1'b1, 4, 0, 0, 1'b0, 0);
            chk("R3 drain pdst", ren_pdst, 23 + k);
        end
        idle_read(4, 6);
        chk("R6 stall when empty", ren_stall, 1);
        chk("R3 r4 last alloc", ren_psrc1, 31);
        drive(1'b1, 6, 0, 0, 1'b0, 0);
        idle_read(6, 0);
        chk("R6 stalled request ignored", ren_psrc1, 6);
        chk("R6 still stalled", ren_stall, 1);

        // R7: release register 16, stall clears next cycle, it is reused
        @(negedge clk);
        free_valid = 1'b1; free_preg = PW'(16);
        @(negedge clk);
        free_valid = 1'b0;
        #1;
        chk("R7 stall cleared", ren_stall, 0);
        drive(1'b1, 6, 6, 0, 1'b0, 0);
        chk("R7 reused pdst", ren_pdst, 16);
        chk("R4 pold r6", ren_pold, 6);
        idle_read(6, 0);
        chk("R7 r6 mapped", ren_psrc1, 16);
        chk("R6 empty again", ren_stall, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule